// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a clocked single-port memory. Every command passes through a two-stage pipeline. Reads and writes both complete on the second enabled clock edge after the command is taken. Because the latency is the same for both, the shared data bus can switch from read to write and back with no idle cycle in between. The bus is modelled as three separate ports: an input word, an output word and a drive-enable flag.

The memory is selected through three enable terms. A clock-enable input can stall the whole block without losing work. Byte-lane write strobes pick which lanes a write updates. An advance/load control either loads a new address or steps a 2-bit burst counter from the last loaded address. The step order is linear (wrapping add) or interleaved (XOR), chosen by a mode input. Memory contents are not cleared by reset.

Top module: `zbt_sram_core`

## Requirements
- R1: A command is accepted only when `sel_a_n_i`=0, `sel_b_n_i`=0 and `sel_c_i`=1. Any other combination inserts an empty slot into the pipeline.
- R2: While `clk_en_n_i`=1, a rising edge changes nothing: no command is taken, the pipeline holds, and read data already on the bus stays driven.
- R3: A read command (`rd_wr_n_i`=1, `adv_ld_i`=0, selected, `clk_en_n_i`=0) puts the word at its address on `bus_out_o` right after the second enabled rising edge that follows the command.
- R4: A write command (`rd_wr_n_i`=0) stores the `bus_in_i` word present at the second enabled rising edge after the command.
- R5: Commands on consecutive enabled edges are pipelined with no idle cycle, in any mix of reads and writes. A read placed after a write to the same address returns the written word.
- R6: A deselected slot does not cancel commands already in flight. Once the last read has been delivered, an empty slot leaves the bus undriven.
- R7: `bus_drive_o` is 1 only when a read result is held and `out_en_n_i`=0.
- R8: A synchronous reset (`rst`=1) clears the pipeline, the burst state and the bus drive, so the bus is undriven after the first clock edge of reset.
- R9: `lane_we_n_i` is sampled with the command. If bit k is 0, the write updates bits [8k+7:8k]; if bit k is 1, those bits keep their old value.
- R10: `adv_ld_i`=1 on a selected, enabled edge after a load adds one (mod 4) to the burst step and repeats the type of the last loaded command. If no command has been loaded since reset, it is an empty slot.
- R11: With `burst_mode_i`=0, the burst address keeps the upper bits of the loaded address, and its low two bits are (loaded low bits + step) mod 4.
- R12: With `burst_mode_i`=1, the low two bits of the burst address are the loaded low bits XOR the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Command address |
| rd_wr_n_i | input | 1 | 1 selects read, 0 selects write |
| adv_ld_i | input | 1 | 0 loads a new address, 1 steps the burst |
| sel_a_n_i | input | 1 | Select term, active low |
| sel_b_n_i | input | 1 | Select term, active low |
| sel_c_i | input | 1 | Select term, active high |
| clk_en_n_i | input | 1 | Clock enable, active low |
| lane_we_n_i | input | DATA_W/8 | Per-lane write strobes, active low |
| out_en_n_i | input | 1 | Output enable, active low |
| burst_mode_i | input | 1 | 0 linear order, 1 interleaved order |
| bus_in_i | input | DATA_W | Bus value seen by the memory |
| bus_out_o | output | DATA_W | Read word placed on the bus |
| bus_drive_o | output | 1 | Bus driver enable |

## Verification
The embedded properties assume that all control inputs are known at every rising edge. They also assume that `bus_in_i` carries the intended write word at the edge where a write retires. The stimulus changes every input only at the falling clock edge. It writes all addresses once before any read, so every read returns a defined word. It then runs directed sequences for stalls, each kind of deselect, output-enable gating, lane masks and both burst orders. A long pseudo-random mix follows, compared every cycle against a queue-based behavioural model.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic { ORDER_LINEAR = 1'b0, ORDER_XOR = 1'b1 } burst_order_e;

  function automatic logic chip_selected(input logic a_n, input logic b_n, input logic c);
    return (!a_n) && (!b_n) && c;
  endfunction

  function automatic logic [1:0] burst_low(input logic [1:0] start, input logic [1:0] step,
                                           input burst_order_e order);
    return (order == ORDER_XOR) ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/zbt_cmd_front.sv
module zbt_cmd_front #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_wr_n_i,
  input  logic              adv_ld_i,
  input  logic              sel_a_n_i,
  input  logic              sel_b_n_i,
  input  logic              sel_c_i,
  input  logic [LANES-1:0]  lane_we_n_i,
  input  logic              burst_mode_i,
  output logic              sel_hit_o,
  output logic              cmd_valid_o,
  output logic              cmd_wr_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [LANES-1:0]  cmd_lanes_o
);
  import zbt_pkg::*;

  logic              live_q, last_wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q, step_nxt;
  burst_order_e      order;

  assign sel_hit_o = chip_selected(sel_a_n_i, sel_b_n_i, sel_c_i);
  assign step_nxt  = step_q + 2'd1;
  assign order     = burst_order_e'(burst_mode_i);

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_wr_o    = last_wr_q;
    cmd_addr_o  = base_q;
    cmd_lanes_o = ~lane_we_n_i;
    if (sel_hit_o) begin
      if (!adv_ld_i) begin
        cmd_valid_o = 1'b1;
        cmd_wr_o    = !rd_wr_n_i;
        cmd_addr_o  = addr_i;
      end else if (live_q) begin
        cmd_valid_o = 1'b1;
        cmd_addr_o  = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], step_nxt, order)};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q    <= 1'b0;
      last_wr_q <= 1'b0;
      base_q    <= '0;
      step_q    <= 2'd0;
    end else if (en && sel_hit_o) begin
      if (!adv_ld_i) begin
        live_q    <= 1'b1;
        last_wr_q <= !rd_wr_n_i;
        base_q    <= addr_i;
        step_q    <= 2'd0;
      end else if (live_q) begin
        step_q <= step_nxt;
      end
    end
  end

  // R10
  burst_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && sel_hit_o && adv_ld_i && live_q) |=> (step_q == $past(step_q) + 2'd1));
endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cmd_valid_i,
  input  logic              cmd_wr_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [LANES-1:0]  cmd_lanes_i,
  output logic              stage1_valid_o,
  output logic              retire_valid_o,
  output logic              retire_wr_o,
  output logic [ADDR_W-1:0] retire_addr_o,
  output logic [LANES-1:0]  retire_lanes_o
);
  logic              s1_valid, s1_wr, s2_valid, s2_wr;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_lanes, s2_lanes;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
    end else if (en) begin
      s1_valid <= cmd_valid_i;
      s2_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s1_wr    <= cmd_wr_i;
      s1_addr  <= cmd_addr_i;
      s1_lanes <= cmd_lanes_i;
      s2_wr    <= s1_wr;
      s2_addr  <= s1_addr;
      s2_lanes <= s1_lanes;
    end
  end

  assign stage1_valid_o = s1_valid;
  assign retire_valid_o = s2_valid;
  assign retire_wr_o    = s2_wr;
  assign retire_addr_o  = s2_addr;
  assign retire_lanes_o = s2_lanes;

  // R2
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable({s1_valid, s2_valid}));
  // R5
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (s2_valid == $past(s1_valid)));
endmodule

// File: rtl/zbt_store.sv
module zbt_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     retire_valid_i,
  input  logic                     retire_wr_i,
  input  logic [ADDR_W-1:0]        retire_addr_i,
  input  logic [DATA_W/LANE_W-1:0] retire_lanes_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic                     rd_valid_o,
  output logic [DATA_W-1:0]        rd_data_o
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic              wr_fire, rd_fire, rd_valid_q;
  logic [DATA_W-1:0] rd_word;

  assign wr_fire = en && retire_valid_i && retire_wr_i;
  assign rd_fire = en && retire_valid_i && !retire_wr_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (wr_fire && retire_lanes_i[g])
        lane_mem[retire_addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      if (rd_fire)
        lane_q <= lane_mem[retire_addr_i];
    end
    assign rd_word[g*LANE_W +: LANE_W] = lane_q;
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_valid_q <= 1'b0;
    else if (en) rd_valid_q <= rd_fire;
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_word;

  // R3
  read_launch_chk: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> rd_valid_q);
  // R6
  bubble_release_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !retire_valid_i) |=> !rd_valid_q);
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     rd_wr_n_i,
  input  logic                     adv_ld_i,
  input  logic                     sel_a_n_i,
  input  logic                     sel_b_n_i,
  input  logic                     sel_c_i,
  input  logic                     clk_en_n_i,
  input  logic [DATA_W/LANE_W-1:0] lane_we_n_i,
  input  logic                     out_en_n_i,
  input  logic                     burst_mode_i,
  input  logic [DATA_W-1:0]        bus_in_i,
  output logic [DATA_W-1:0]        bus_out_o,
  output logic                     bus_drive_o
);
  localparam int LANES = DATA_W / LANE_W;

  logic              en, sel_hit, stage1_valid, rd_valid;
  logic              cmd_valid, cmd_wr, ret_valid, ret_wr;
  logic [ADDR_W-1:0] cmd_addr, ret_addr;
  logic [LANES-1:0]  cmd_lanes, ret_lanes;

  assign en = !clk_en_n_i;

  zbt_cmd_front #(.ADDR_W(ADDR_W), .LANES(LANES)) front_i (
    .clk(clk), .rst(rst), .en(en), .addr_i(addr_i), .rd_wr_n_i(rd_wr_n_i),
    .adv_ld_i(adv_ld_i), .sel_a_n_i(sel_a_n_i), .sel_b_n_i(sel_b_n_i), .sel_c_i(sel_c_i),
    .lane_we_n_i(lane_we_n_i), .burst_mode_i(burst_mode_i), .sel_hit_o(sel_hit),
    .cmd_valid_o(cmd_valid), .cmd_wr_o(cmd_wr), .cmd_addr_o(cmd_addr), .cmd_lanes_o(cmd_lanes));

  zbt_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) pipe_i (
    .clk(clk), .rst(rst), .en(en), .cmd_valid_i(cmd_valid), .cmd_wr_i(cmd_wr),
    .cmd_addr_i(cmd_addr), .cmd_lanes_i(cmd_lanes), .stage1_valid_o(stage1_valid),
    .retire_valid_o(ret_valid), .retire_wr_o(ret_wr), .retire_addr_o(ret_addr),
    .retire_lanes_o(ret_lanes));

  zbt_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) store_i (
    .clk(clk), .rst(rst), .en(en), .retire_valid_i(ret_valid), .retire_wr_i(ret_wr),
    .retire_addr_i(ret_addr), .retire_lanes_i(ret_lanes), .wdata_i(bus_in_i),
    .rd_valid_o(rd_valid), .rd_data_o(bus_out_o));

  assign bus_drive_o = rd_valid && !out_en_n_i;

  // R1
  deselect_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !sel_hit) |=> !stage1_valid);
  // R8
  powerup_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !bus_drive_o);
  // R2
  hold_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en_n_i && rd_valid) |=> rd_valid && $stable(bus_out_o));
endmodule

// File: tb/zbt_sram_core_tb_top.sv
`timescale 1ns/1ps
module zbt_sram_core_tb_top;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic rw = 1'b1, adv = 1'b0, sa_n = 1'b1, sb_n = 1'b0, sc = 1'b1;
  logic cen = 1'b0, oe_n = 1'b0, mode = 1'b0;
  logic [3:0] we_n = 4'hF;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic drive;

  always #2.5 clk = ~clk;

  zbt_sram_core dut_i (
    .clk(clk), .rst(rst), .addr_i(addr), .rd_wr_n_i(rw), .adv_ld_i(adv),
    .sel_a_n_i(sa_n), .sel_b_n_i(sb_n), .sel_c_i(sc), .clk_en_n_i(cen),
    .lane_we_n_i(we_n), .out_en_n_i(oe_n), .burst_mode_i(mode), .bus_in_i(din),
    .bus_out_o(dout), .bus_drive_o(drive));

  typedef struct { bit v; bit w; int a; bit [3:0] l; } op_t;
  op_t pend[$];
  logic [31:0] mm [64];
  bit exp_v; logic [31:0] exp_d;
  bit have; bit lastw; int base; int stp;
  int vectors = 0, miscompares = 0;
  string tag = "R8";
  logic [31:0] seed = 32'h1234_5678;
  int cyc = 0;

  function automatic int burst_addr(int b, int s, bit m);
    int lo;
    if (m) lo = (b % 4) ^ s;
    else   lo = ((b % 4) + s) % 4;
    return (b / 4) * 4 + lo;
  endfunction

  task automatic model_edge();
    op_t n, e;
    if (rst) begin
      pend.delete(); n.v = 0; n.w = 0; n.a = 0; n.l = 0;
      pend.push_back(n); pend.push_back(n);
      exp_v = 0; have = 0; stp = 0;
      return;
    end
    if (cen) return;
    n.v = 0; n.w = 0; n.a = 0; n.l = ~we_n;
    if (!sa_n && !sb_n && sc) begin
      if (!adv) begin
        n.v = 1; n.w = !rw; n.a = int'(addr);
        base = int'(addr); stp = 0; have = 1; lastw = !rw;
      end else if (have) begin
        stp = (stp + 1) % 4;
        n.v = 1; n.w = lastw; n.a = burst_addr(base, stp, mode);
      end
    end
    pend.push_back(n);
    e = pend.pop_front();
    exp_v = 0;
    if (e.v && e.w) begin
      for (int k = 0; k < 4; k++)
        if (e.l[k]) mm[e.a][k*8 +: 8] = din[k*8 +: 8];
    end else if (e.v) begin
      exp_v = 1; exp_d = mm[e.a];
    end
  endtask

  task automatic compare();
    bit ed;
    ed = exp_v && !oe_n;
    vectors++;
    if (drive !== ed) begin
      miscompares++;
      $display("FAIL %s cycle %0d drive actual=%b expected=%b", tag, cyc, drive, ed);
    end else if (ed && dout !== exp_d) begin
      miscompares++;
      $display("FAIL %s cycle %0d data actual=%h expected=%h", tag, cyc, dout, exp_d);
    end
  endtask

  task automatic step();
    seed = seed * 32'd1103515245 + 32'd12345;
    din = seed ^ (cyc * 32'h9E3779B1);
    @(posedge clk);
    model_edge();
    cyc++;
    @(negedge clk);
    compare();
  endtask

  task automatic cmd(bit r, int a, bit ad, logic [3:0] wn);
    cen = 0; sa_n = 0; sb_n = 0; sc = 1; rw = r; addr = a[AW-1:0]; adv = ad; we_n = wn;
    step();
  endtask

  task automatic deselect(int kind);
    cen = 0; adv = 0; sa_n = 0; sb_n = 0; sc = 1;
    if (kind == 0) sa_n = 1; else if (kind == 1) sb_n = 1; else sc = 0;
    step();
  endtask

  task automatic stall();
    cen = 1; step(); cen = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    miscompares++;
    $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R8: reset state, bus undriven
    tag = "R8";
    repeat (3) step();
    rst = 0;
    // R4 R5: fill every address back-to-back with writes
    tag = "R4";
    for (int i = 0; i < 64; i++) cmd(0, i, 0, 4'h0);
    deselect(0); deselect(0);
    // R3 R5: back-to-back reads
    tag = "R3";
    for (int i = 0; i < 8; i++) cmd(1, i * 7, 0, 4'hF);
    deselect(1); deselect(1); deselect(1);
    // R5: alternating write/read including read-after-write same address
    tag = "R5";
    for (int i = 0; i < 12; i++) begin
      cmd(0, i + 10, 0, 4'h0);
      cmd(1, i + 10, 0, 4'hF);
    end
    deselect(2); deselect(2);
    // R2: stalls mid-stream keep data held
    tag = "R2";
    cmd(1, 3, 0, 4'hF); stall(); cmd(1, 4, 0, 4'hF); stall(); stall();
    deselect(0); stall(); stall(); deselect(0); cmd(0, 5, 0, 4'h0); stall(); deselect(0); stall(); deselect(0);
    cmd(1, 5, 0, 4'hF); deselect(0); deselect(0); stall(); stall(); deselect(0);
    // R1 R6: each deselect kind between reads; in-flight data delivered
    tag = "R1";
    for (int k = 0; k < 3; k++) begin
      cmd(1, 20 + k, 0, 4'hF); deselect(k); cmd(1, 30 + k, 0, 4'hF); deselect(k); deselect(k);
    end
    tag = "R6";
    cmd(1, 40, 0, 4'hF); deselect(1); deselect(1); deselect(1); deselect(1);
    // R7: output enable gating
    tag = "R7";
    oe_n = 1; cmd(1, 41, 0, 4'hF); cmd(1, 42, 0, 4'hF); cmd(1, 43, 0, 4'hF);
    oe_n = 0; deselect(0); oe_n = 1; deselect(0); oe_n = 0; deselect(0);
    // R9: partial lane writes, then read back
    tag = "R9";
    cmd(0, 50, 0, 4'b1110); cmd(0, 51, 0, 4'b0101); cmd(0, 52, 0, 4'b1111); cmd(0, 53, 0, 4'b0111);
    cmd(1, 50, 0, 4'hF); cmd(1, 51, 0, 4'hF); cmd(1, 52, 0, 4'hF); cmd(1, 53, 0, 4'hF);
    deselect(2); deselect(2);
    // R10 R11: linear bursts from a non-aligned start
    tag = "R11";
    mode = 0;
    cmd(0, 45, 0, 4'h0); cmd(0, 0, 1, 4'h0); cmd(0, 0, 1, 4'h0); cmd(0, 0, 1, 4'h0); cmd(0, 0, 1, 4'h0);
    tag = "R10";
    cmd(1, 46, 0, 4'hF); cmd(0, 0, 1, 4'hF); cmd(0, 0, 1, 4'hF); cmd(1, 0, 1, 4'hF);
    cmd(1, 44, 0, 4'hF); cmd(1, 45, 0, 4'hF); cmd(1, 46, 0, 4'hF); cmd(1, 47, 0, 4'hF);
    deselect(0); deselect(0);
    // R12: interleaved bursts
    tag = "R12";
    mode = 1;
    cmd(0, 58, 0, 4'h0); cmd(0, 0, 1, 4'h0); cmd(0, 0, 1, 4'h0); cmd(0, 0, 1, 4'h0);
    cmd(1, 59, 0, 4'hF); cmd(1, 0, 1, 4'hF); cmd(1, 0, 1, 4'hF); cmd(1, 0, 1, 4'hF);
    deselect(0); deselect(0); deselect(0);
    // R8 R10: reset with reads in flight; burst with nothing loaded is empty
    tag = "R8";
    cmd(1, 1, 0, 4'hF); cmd(1, 2, 0, 4'hF); rst = 1; step(); rst = 0;
    tag = "R10";
    cmd(1, 0, 1, 4'hF); cmd(1, 0, 1, 4'hF); deselect(0); deselect(0);
    // mixed pseudo-random traffic
    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      seed = seed * 32'd1103515245 + 32'd12345;
      r = seed;
      mode = r[20];
      oe_n = (r[23:21] == 3'd0);
      if (r[26:24] == 3'd0) stall();
      else if (r[29:27] == 3'd0) deselect(int'(r[1:0]) % 3);
      else cmd(r[2], int'(r[10:5]), r[12:11] == 2'd0, r[16:13] ^ {4{r[17]}});
    end
    oe_n = 0; deselect(0); deselect(0); deselect(0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule